// File: doc/BRIEF.md
# OVSF Channelization Code Generator

This block produces the chip stream of one orthogonal variable spreading factor channelization code in real time, one chip for each chip-rate enable. No code tree or table is held in storage. A chip counter steps through one code period, and each chip is the parity of those code-index bits that the counter selects. The code index is read in bit-reversed order against the counter. The spreading factor arrives as a base-2 logarithm, so a single datapath covers every length from 4 to 512 chips.

A start strobe loads the requested spreading factor and code index and restarts the period at chip 0. After that the generator keeps running. It samples a new spreading factor and index only where one period ends and the next begins, so a spreading stage downstream never sees a code switch in the middle of a symbol. Each emitted chip comes with a valid flag, and the last chip of each period also raises an end-of-period flag.

Top module: `ovsf_code_gen`

## Requirements
- R1: After reset `chip_vld`, `chip_bit` and `period_end` are 0, and no chip is emitted until `start` has been seen.
- R2: A chip value of +1 is output as `chip_bit`=0 and a value of -1 as `chip_bit`=1. With L = log2(SF) and counter value c, the chip is the XOR over k in 0..L-1 of (c[k] AND N[L-1-k]), so the counter LSB gates the MSB of N.
- R3: For every N at SF 4, 8 and 16, the chip sequence equals the code built by the doubling rule: C(2S,2m) = [C(S,m), C(S,m)] and C(2S,2m+1) = [C(S,m), NOT C(S,m)], from C(1,0) = 0. For example C(8,5) = 0,1,0,1,1,0,1,0.
- R4: `sf_log2` values 2..9 give SF = 2^sf_log2. Values below 2 are treated as 2 and values above 9 as 9.
- R5: Long codes work up to SF=512. C(256,0) is 256 chips of 0.
- R6: When `chip_en` is high in a cycle without `start` (after a start), exactly one chip is output with `chip_vld`=1 on the next cycle. A cycle without `chip_en` gives `chip_vld`=0 on the next cycle and does not advance the counter.
- R7: `period_end` is 1 only together with the chip at counter value SF-1. The following chip is counter value 0 of the next period.
- R8: Changes to `sf_log2` or `code_idx` during a period do not affect the rest of that period. They take effect from chip 0 of the next period.
- R9: `start` resets the counter to 0 and loads `sf_log2` and `code_idx` in the same cycle. It takes priority over `chip_en`, so that cycle emits no chip.
- R10: Bits of `code_idx` at positions L and above have no effect on the chips.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Load configuration and restart at chip 0 |
| chip_en | input | 1 | Chip-rate enable: emit one chip |
| sf_log2 | input | 4 | log2 of the spreading factor requested |
| code_idx | input | 9 | Code index N requested |
| chip_bit | output | 1 | Chip value, 0 = +1, 1 = -1 |
| chip_vld | output | 1 | Chip output valid |
| period_end | output | 1 | Last chip of the code period |

## Verification
The hardest case to reach from the ports is a configuration change that lands inside a running period. Reaching it needs the bench to keep count of the chips already emitted and to change `sf_log2` and `code_idx` between two enabled chips. The bench does this with a period of 4 chips: after two chips it moves to a period of 8 with a different index. It then checks that the two remaining chips of the old code come first and that the new code starts at chip 0. A restart during a long code and gaps in `chip_en` reach the other mid-period cases in the same way.

// File: rtl/ovsf_pkg.sv
// Package: shared helpers for the OVSF code generator.
// Assumes integer arguments are small (spreading-factor exponents).
package ovsf_pkg;

    // Limit a requested spreading-factor exponent to the supported range.
    function automatic int clamp_log2(input int req, input int lo, input int hi);
        if (req < lo) begin
            return lo;
        end
        if (req > hi) begin
            return hi;
        end
        return req;
    endfunction

endpackage

// File: rtl/ovsf_cfg_shadow.sv
// Module: ovsf_cfg_shadow
// Holds the code configuration that is in use. A requested spreading-factor
// exponent is clamped into [LOG2_MIN, LOG2_MAX] and captured together with the
// code index only when load is high (a restart or a period boundary).
// Assumes load is a single-cycle qualified event from the top level.
module ovsf_cfg_shadow #(
    parameter int LOG2_MIN = 2,
    parameter int LOG2_MAX = 9,
    parameter int SFW      = $clog2(LOG2_MAX + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [SFW-1:0]      sf_req,
    input  logic [LOG2_MAX-1:0] idx_req,
    output logic [SFW-1:0]      sf_act,
    output logic [LOG2_MAX-1:0] idx_act
);
    import ovsf_pkg::*;

    logic [SFW-1:0] sf_clamped;

    // Clamp the requested exponent into the supported range.
    always_comb begin
        sf_clamped = SFW'(clamp_log2(int'(sf_req), LOG2_MIN, LOG2_MAX));
    end

    // Capture the configuration on a restart or at a period boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sf_act  <= SFW'(LOG2_MIN);
            idx_act <= '0;
        end else if (load) begin
            sf_act  <= sf_clamped;
            idx_act <= idx_req;
        end
    end

endmodule

// File: rtl/ovsf_chip_counter.sv
// Module: ovsf_chip_counter
// Chip position counter for one code period of 2^sf_act chips. It clears on
// clr, steps on adv and wraps after the last position. It also drives a lane
// mask that marks the counter bits belonging to the active length.
// Assumes sf_act stays constant within a period.
module ovsf_chip_counter #(
    parameter int LOG2_MAX = 9,
    parameter int SFW      = $clog2(LOG2_MAX + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                adv,
    input  logic [SFW-1:0]      sf_act,
    output logic [LOG2_MAX-1:0] cnt,
    output logic [LOG2_MAX-1:0] lane_mask,
    output logic                last
);

    // One mask bit per counter bit that lies below the active exponent.
    for (genvar k = 0; k < LOG2_MAX; k++) begin : g_lane
        assign lane_mask[k] = (k < int'(sf_act));
    end

    // The last position has every active counter bit set.
    assign last = (cnt == lane_mask);

    // Clear on restart, step on each chip, wrap after the last chip.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (adv) begin
            if (last) begin
                cnt <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/ovsf_chip_xor.sv
// Module: ovsf_chip_xor
// Combinational chip former. The code index is bit-reversed over the active
// length L, so counter bit k pairs with index bit L-1-k. Only pairs whose
// counter bit is set take part in the parity. Index bits at L and above are
// never selected. Assumes lane_mask marks exactly the low L bits.
module ovsf_chip_xor #(
    parameter int LOG2_MAX = 9,
    parameter int SFW      = $clog2(LOG2_MAX + 1)
) (
    input  logic [SFW-1:0]      sf_act,
    input  logic [LOG2_MAX-1:0] cnt,
    input  logic [LOG2_MAX-1:0] idx,
    input  logic [LOG2_MAX-1:0] lane_mask,
    output logic                chip
);

    logic [LOG2_MAX-1:0] idx_rev;
    logic [LOG2_MAX-1:0] gated;

    // Reverse the active index bits against the counter lanes.
    always_comb begin
        idx_rev = '0;
        for (int k = 0; k < LOG2_MAX; k++) begin
            for (int j = 0; j < LOG2_MAX; j++) begin
                if ((k < int'(sf_act)) && (j == int'(sf_act) - 1 - k)) begin
                    idx_rev[k] = idx[j];
                end
            end
        end
    end

    // Keep only active lanes whose counter bit selects the index bit.
    for (genvar k = 0; k < LOG2_MAX; k++) begin : g_gate
        assign gated[k] = cnt[k] & lane_mask[k] & idx_rev[k];
    end

    assign chip = ^gated;

endmodule

// File: rtl/ovsf_code_gen.sv
// Module: ovsf_code_gen (top)
// OVSF channelization code generator. start loads the configuration and
// restarts the period. Each later chip_en yields one registered chip with its
// valid flag. The configuration reloads on the cycle that emits the last chip
// of a period. Assumes chip_en is a one-cycle chip-rate strobe or held high.
module ovsf_code_gen #(
    parameter int LOG2_MIN = 2,
    parameter int LOG2_MAX = 9,
    parameter int SFW      = $clog2(LOG2_MAX + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                chip_en,
    input  logic [SFW-1:0]      sf_log2,
    input  logic [LOG2_MAX-1:0] code_idx,
    output logic                chip_bit,
    output logic                chip_vld,
    output logic                period_end
);

    logic                running;
    logic                fire;
    logic                reload;
    logic [SFW-1:0]      sf_act;
    logic [LOG2_MAX-1:0] idx_act;
    logic [LOG2_MAX-1:0] cnt;
    logic [LOG2_MAX-1:0] lane_mask;
    logic                last;
    logic                chip_now;

    assign fire   = running & chip_en & ~start;
    assign reload = start | (fire & last);

    ovsf_cfg_shadow #(
        .LOG2_MIN (LOG2_MIN),
        .LOG2_MAX (LOG2_MAX),
        .SFW      (SFW)
    ) cfg_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (reload),
        .sf_req  (sf_log2),
        .idx_req (code_idx),
        .sf_act  (sf_act),
        .idx_act (idx_act)
    );

    ovsf_chip_counter #(
        .LOG2_MAX (LOG2_MAX),
        .SFW      (SFW)
    ) cnt_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (start),
        .adv       (fire),
        .sf_act    (sf_act),
        .cnt       (cnt),
        .lane_mask (lane_mask),
        .last      (last)
    );

    ovsf_chip_xor #(
        .LOG2_MAX (LOG2_MAX),
        .SFW      (SFW)
    ) xor_i (
        .sf_act    (sf_act),
        .cnt       (cnt),
        .idx       (idx_act),
        .lane_mask (lane_mask),
        .chip      (chip_now)
    );

    // Remember that a start has been seen; chips flow only after it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
        end else if (start) begin
            running <= 1'b1;
        end
    end

    // Register the chip, its valid flag and the end-of-period marker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chip_bit   <= 1'b0;
            chip_vld   <= 1'b0;
            period_end <= 1'b0;
        end else begin
            chip_vld   <= fire;
            chip_bit   <= fire & chip_now;
            period_end <= fire & last;
        end
    end

endmodule

// File: rtl/ovsf_code_gen_chk.sv
// Module: ovsf_code_gen_chk
// Port-level protocol checks for ovsf_code_gen, attached with bind.
module ovsf_code_gen_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic chip_en,
    input logic chip_vld,
    input logic period_end
);

    logic seen_start;

    // Track whether a start strobe has occurred since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_start <= 1'b0;
        end else if (start) begin
            seen_start <= 1'b1;
        end
    end

    a_r1_idle_until_start: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_start |-> !chip_vld);

    a_r6_no_en_no_chip: assert property (@(posedge clk) disable iff (!rst_n)
        !chip_en |=> !chip_vld);

    a_r6_en_gives_chip: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_start && chip_en && !start) |=> chip_vld);

    a_r9_start_wins: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !chip_vld);

    a_r7_end_with_chip: assert property (@(posedge clk) disable iff (!rst_n)
        period_end |-> chip_vld);

    a_r7_end_isolated: assert property (@(posedge clk) disable iff (!rst_n)
        period_end |=> !period_end);

endmodule

bind ovsf_code_gen ovsf_code_gen_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .chip_en    (chip_en),
    .chip_vld   (chip_vld),
    .period_end (period_end)
);

// File: tb/ovsf_code_gen_tb_top.sv
`timescale 1ns/1ps
module ovsf_code_gen_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       chip_en = 1'b0;
    logic [3:0] sf_log2 = 4'd2;
    logic [8:0] code_idx = 9'd0;
    logic       chip_bit;
    logic       chip_vld;
    logic       period_end;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    ovsf_code_gen dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .chip_en    (chip_en),
        .sf_log2    (sf_log2),
        .code_idx   (code_idx),
        .chip_bit   (chip_bit),
        .chip_vld   (chip_vld),
        .period_end (period_end)
    );

    // Record one check; print a line on mismatch.
    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Code by the doubling rule, built level by level from the root.
    function automatic logic [511:0] build_code(input int s, input int n);
        logic [511:0] seq;
        int len;
        seq = '0;
        len = 1;
        for (int l = 1; l <= s; l++) begin
            for (int j = 0; j < len; j++) begin
                seq[len + j] = seq[j] ^ n[s - l];
            end
            len = len * 2;
        end
        return seq;
    endfunction

    // Issue a start with the given configuration.
    task automatic do_start(input int sfl, input int n);
        @(negedge clk);
        sf_log2  = 4'(sfl);
        code_idx = 9'(n);
        start    = 1'b1;
        chip_en  = 1'b0;
        @(negedge clk);
        start = 1'b0;
        check(chip_vld == 1'b0, "R9", int'(chip_vld), 0);
    endtask

    // Emit cnt chips back to back and compare them with code C(2^s, n) from offset.
    task automatic run_chips(input int count, input int s, input int n, input int offset,
                             input string req);
        logic [511:0] ref_seq;
        int sf;
        ref_seq = build_code(s, n);
        sf = 1 << s;
        chip_en = 1'b1;
        for (int i = 0; i < count; i++) begin
            int pos;
            pos = (offset + i) % sf;
            @(negedge clk);
            check(chip_vld == 1'b1, "R6", int'(chip_vld), 1);
            check(chip_bit == ref_seq[pos], req, int'(chip_bit), int'(ref_seq[pos]));
            check(period_end == (pos == sf - 1), "R7", int'(period_end), int'(pos == sf - 1));
        end
        chip_en = 1'b0;
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chip_en = 1'b1;
        repeat (3) @(negedge clk);
        check(chip_vld == 1'b0, "R1", int'(chip_vld), 0);
        check(chip_bit == 1'b0, "R1", int'(chip_bit), 0);
        check(period_end == 1'b0, "R1", int'(period_end), 0);
        chip_en = 1'b0;
    endtask

    // R3: every index at SF 4, 8 and 16 against the doubling rule.
    task automatic t_sweep;
        for (int s = 2; s <= 4; s++) begin
            for (int n = 0; n < (1 << s); n++) begin
                do_start(s, n);
                run_chips(1 << s, s, n, 0, "R3");
            end
        end
    endtask

    // R2: worked example C(8,5) with literal chips, two periods to show the wrap.
    task automatic t_example;
        logic [7:0] lit;
        lit = 8'b01011010;
        do_start(3, 5);
        chip_en = 1'b1;
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            check(chip_bit == lit[7 - (i % 8)], "R2", int'(chip_bit), int'(lit[7 - (i % 8)]));
        end
        chip_en = 1'b0;
    endtask

    // R5: all-zero code of length 256, and a long code of length 512.
    task automatic t_long;
        do_start(8, 0);
        run_chips(256, 8, 0, 0, "R5");
        do_start(9, 300);
        run_chips(512, 9, 300, 0, "R5");
    endtask

    // R4: exponent below range acts as 4 chips, above range as 512.
    task automatic t_clamp;
        do_start(0, 3);
        run_chips(8, 2, 3, 0, "R4");
        do_start(15, 77);
        run_chips(512, 9, 77, 0, "R4");
    endtask

    // R6: gaps in chip_en emit nothing and do not advance the code.
    task automatic t_gaps;
        logic [511:0] ref_seq;
        ref_seq = build_code(3, 6);
        do_start(3, 6);
        for (int i = 0; i < 8; i++) begin
            chip_en = 1'b1;
            @(negedge clk);
            chip_en = 1'b0;
            check(chip_vld == 1'b1, "R6", int'(chip_vld), 1);
            check(chip_bit == ref_seq[i], "R6", int'(chip_bit), int'(ref_seq[i]));
            @(negedge clk);
            check(chip_vld == 1'b0, "R6", int'(chip_vld), 0);
        end
    endtask

    // R8: a mid-period change waits for the boundary.
    task automatic t_boundary;
        do_start(2, 1);
        run_chips(2, 2, 1, 0, "R8");
        sf_log2  = 4'd3;
        code_idx = 9'd2;
        run_chips(2, 2, 1, 2, "R8");
        run_chips(8, 3, 2, 0, "R8");
    endtask

    // R9: start during a long period restarts at chip 0 with the new code.
    task automatic t_restart;
        do_start(4, 7);
        run_chips(5, 4, 7, 0, "R9");
        do_start(2, 1);
        run_chips(4, 2, 1, 0, "R9");
        @(negedge clk);
        sf_log2 = 4'd3;
        code_idx = 9'd6;
        start = 1'b1;
        chip_en = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(chip_vld == 1'b0, "R9", int'(chip_vld), 0);
        run_chips(8, 3, 6, 0, "R9");
    endtask

    // R10: upper index bits beyond the code length are ignored.
    task automatic t_upper_bits;
        do_start(2, 9'b1_0110_0010);
        run_chips(4, 2, 2, 0, "R10");
        do_start(3, 9'b1_1111_1101);
        run_chips(8, 3, 5, 0, "R10");
    endtask

    initial begin
        t_reset();
        t_sweep();
        t_example();
        t_long();
        t_clamp();
        t_gaps();
        t_boundary();
        t_restart();
        t_upper_bits();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule